// File: doc/BRIEF.md
# Banked Paged Register File

This block is the byte-wide register file of a small microcontroller core. The core gives it an 8-bit register address and a tag for the addressing mode. The block steers the access to physical storage using a 4-bit page pointer and a two-state bank selector, both of which it holds itself.

The lower 192 addresses form a prime area that is replicated for each general-purpose page and is reachable in every mode. The top 64 addresses lead to one of two places. With direct register addressing they reach a system set, which is the same whatever the page pointer holds. Its lower 32 bytes are common, and its upper 32 bytes exist twice, once for each bank. With indirect, indexed or stack addressing, the same 64 addresses reach a per-page upper set instead. One extra page carries only a small display area. All other locations on that page, and everything on pages that do not exist, read as zero and ignore writes.

The block has one combinational read port and one write port that writes on the clock edge. The bank selector is a two-state machine with the states `BANK0` and `BANK1`. Its transitions are `SEL0` (select-bank-0 alone moves it to `BANK0`), `SEL1` (select-bank-1 alone moves it to `BANK1`) and `HOLD` (both or neither asserted keeps the current state).

Top module: `banked_regfile`

## Requirements
- R1: An active-low asynchronous reset puts the bank selector in `BANK0` and the page pointer at 0. Storage contents are not reset.
- R2: When `pp_we` is high at a clock edge, the page pointer loads `pp_wdata`. The new page steers accesses from the next cycle on. Without `pp_we` the page pointer holds.
- R3: `sb1` alone selects bank 1 from the next cycle. `sb0` alone selects bank 0. Both high or both low leaves the bank unchanged.
- R4: Addresses 00h–BFh reach a 192-byte prime area of the page the pointer selects, in every addressing mode. This applies to pointer values 0 to `GP_PAGES`-1. Mode encoding: 0 direct register, 1 indirect register, 2 indexed, 3 stack.
- R5: In mode 0, addresses C0h–FFh reach the system set whatever value the page pointer holds, including unimplemented pages.
- R6: Within the system set, C0h–DFh is one common area shared by both banks. E0h–FFh has separate storage for bank 0 and bank 1.
- R7: In modes 1, 2 and 3, addresses C0h–FFh reach a 64-byte upper set that belongs to the current general-purpose page. It is separate from the system set.
- R8: When the pointer equals `DISP_PAGE`, addresses below `DISP_BYTES` reach the display area. All other non-system-set accesses on that page read 00h and writes to them are ignored.
- R9: When the pointer names a page that is neither general-purpose nor the display page, every non-system-set read returns 00h and every such write is ignored.
- R10: A write takes effect at the clock edge. A read of the same resolved location in the same cycle returns the old byte, and the new byte is seen on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pp_we | input | 1 | Page pointer load strobe |
| pp_wdata | input | 4 | New page pointer value |
| sb0 | input | 1 | Select bank 0 |
| sb1 | input | 1 | Select bank 1 |
| rd_addr | input | 8 | Read register address |
| rd_mode | input | 2 | Read addressing mode |
| rd_data | output | 8 | Read data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 8 | Write register address |
| wr_mode | input | 2 | Write addressing mode |
| wr_data | input | 8 | Write data |

## Verification
The bench builds the block with its default parameters: four general-purpose pages, the display page at index 4, and 16 display bytes. With a 4-bit pointer, this leaves values 5 to 15 unimplemented. The bench drives pointer values 0 to 7, so it reaches every general-purpose page, the display page with its unbacked holes, and empty pages. At the same time it mixes all four modes over C0h–FFh, so the direct/indirect aliasing and bank switching across E0h–FFh occur on both sides of page changes.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;

    typedef enum logic [1:0] {
        AM_DIRECT   = 2'd0,
        AM_INDIRECT = 2'd1,
        AM_INDEXED  = 2'd2,
        AM_STACK    = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIME,
        RG_UPPER,
        RG_COMMON,
        RG_BANKED,
        RG_DISP
    } region_e;

    typedef enum logic {
        BANK0 = 1'b0,
        BANK1 = 1'b1
    } bank_e;

    localparam int PRIME_BYTES = 192;
    localparam int UPPER_BYTES = 64;
    localparam int HALF_BYTES  = 32;
    localparam int UPPER_START = 192;
    localparam int BANK_START  = 224;
    localparam int PP_W        = 4;

endpackage

// File: rtl/regfile_decode.sv
module regfile_decode
    import banked_regfile_pkg::*;
#(
    parameter int GP_PAGES   = 4,
    parameter int DISP_PAGE  = 4,
    parameter int DISP_BYTES = 16,
    parameter int IDX_W      = 11
) (
    input  logic [7:0]      addr,
    input  amode_e          mode,
    input  logic [PP_W-1:0] page,
    input  bank_e           bank,
    output logic            hit,
    output logic [IDX_W-1:0] idx
);
    localparam int UPPER_BASE  = GP_PAGES * PRIME_BYTES;
    localparam int COMMON_BASE = UPPER_BASE + GP_PAGES * UPPER_BYTES;
    localparam int BANKED_BASE = COMMON_BASE + HALF_BYTES;
    localparam int DISP_BASE   = BANKED_BASE + 2 * HALF_BYTES;

    region_e region;
    int      a_i;
    int      p_i;
    int      off;

    assign a_i = int'(addr);
    assign p_i = int'(page);

    // Region selection: direct mode on the top window wins over paging
    always_comb begin
        if (a_i >= UPPER_START && mode == AM_DIRECT) begin
            region = (a_i < BANK_START) ? RG_COMMON : RG_BANKED;
        end else if (p_i < GP_PAGES) begin
            region = (a_i < UPPER_START) ? RG_PRIME : RG_UPPER;
        end else if (p_i == DISP_PAGE && a_i < DISP_BYTES) begin
            region = RG_DISP;
        end else begin
            region = RG_NONE;
        end
    end

    // Offset inside the flat store
    always_comb begin
        unique case (region)
            RG_PRIME:  off = p_i * PRIME_BYTES + a_i;
            RG_UPPER:  off = UPPER_BASE + p_i * UPPER_BYTES + (a_i - UPPER_START);
            RG_COMMON: off = COMMON_BASE + (a_i - UPPER_START);
            RG_BANKED: off = BANKED_BASE + ((bank == BANK1) ? HALF_BYTES : 0)
                             + (a_i - BANK_START);
            RG_DISP:   off = DISP_BASE + a_i;
            default:   off = 0;
        endcase
    end

    assign hit = (region != RG_NONE);
    assign idx = IDX_W'(off);

endmodule

// File: rtl/regfile_bank_fsm.sv
module regfile_bank_fsm
    import banked_regfile_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sel0,
    input  logic  sel1,
    output bank_e bank
);
    bank_e state_q;
    bank_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BANK0;
        else        state_q <= state_d;
    end

    // SEL0 / SEL1 / HOLD transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BANK0: if (sel1 && !sel0) state_d = BANK1;
            BANK1: if (sel0 && !sel1) state_d = BANK0;
            default: state_d = BANK0;
        endcase
    end

    assign bank = state_q;

endmodule

// File: rtl/regfile_page_reg.sv
module regfile_page_reg
    import banked_regfile_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PP_W-1:0] din,
    output logic [PP_W-1:0] page
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    page <= '0;
        else if (load) page <= din;
    end
endmodule

// File: rtl/regfile_store.sv
module regfile_store #(
    parameter int DEPTH = 1136,
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && int'(waddr) < DEPTH) mem[waddr] <= wdata;
    end

    assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : 8'h00;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import banked_regfile_pkg::*;
#(
    parameter int GP_PAGES   = 4,
    parameter int DISP_PAGE  = 4,
    parameter int DISP_BYTES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pp_we,
    input  logic [3:0] pp_wdata,
    input  logic       sb0,
    input  logic       sb1,
    input  logic [7:0] rd_addr,
    input  logic [1:0] rd_mode,
    output logic [7:0] rd_data,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [1:0] wr_mode,
    input  logic [7:0] wr_data
);
    localparam int DEPTH = GP_PAGES * (PRIME_BYTES + UPPER_BYTES)
                         + 3 * HALF_BYTES + DISP_BYTES;
    localparam int IDX_W = $clog2(DEPTH);

    logic [PP_W-1:0]  pp_q;
    bank_e            bank_q;
    logic             bank1;
    logic             rd_hit;
    logic             wr_hit;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       store_rd;

    assign bank1 = (bank_q == BANK1);

    regfile_page_reg u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pp_we),
        .din   (pp_wdata),
        .page  (pp_q)
    );

    regfile_bank_fsm u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .sel0  (sb0),
        .sel1  (sb1),
        .bank  (bank_q)
    );

    regfile_decode #(
        .GP_PAGES   (GP_PAGES),
        .DISP_PAGE  (DISP_PAGE),
        .DISP_BYTES (DISP_BYTES),
        .IDX_W      (IDX_W)
    ) u_rd_dec (
        .addr (rd_addr),
        .mode (amode_e'(rd_mode)),
        .page (pp_q),
        .bank (bank_q),
        .hit  (rd_hit),
        .idx  (rd_idx)
    );

    regfile_decode #(
        .GP_PAGES   (GP_PAGES),
        .DISP_PAGE  (DISP_PAGE),
        .DISP_BYTES (DISP_BYTES),
        .IDX_W      (IDX_W)
    ) u_wr_dec (
        .addr (wr_addr),
        .mode (amode_e'(wr_mode)),
        .page (pp_q),
        .bank (bank_q),
        .hit  (wr_hit),
        .idx  (wr_idx)
    );

    regfile_store #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_store (
        .clk   (clk),
        .we    (wr_en && wr_hit),
        .waddr (wr_idx),
        .wdata (wr_data),
        .raddr (rd_idx),
        .rdata (store_rd)
    );

    assign rd_data = rd_hit ? store_rd : 8'h00;

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
    parameter int GP_PAGES   = 4,
    parameter int DISP_PAGE  = 4,
    parameter int DISP_BYTES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pp_we,
    input logic [3:0] pp_wdata,
    input logic       sb0,
    input logic       sb1,
    input logic [7:0] rd_addr,
    input logic [1:0] rd_mode,
    input logic [7:0] rd_data,
    input logic [3:0] pp_q,
    input logic       bank1
);
    localparam logic [3:0] GP_LIM = 4'(GP_PAGES);
    localparam logic [3:0] DISP_P = 4'(DISP_PAGE);
    localparam logic [7:0] DISP_N = 8'(DISP_BYTES);

    logic non_sys;
    assign non_sys = (rd_mode != 2'd0) || (rd_addr < 8'hC0);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pp_q == 4'd0 && !bank1));

    // R2
    pp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pp_we |=> (pp_q == $past(pp_wdata)));

    // R2
    pp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pp_we |=> $stable(pp_q));

    // R3
    bank_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sb1 && !sb0) |=> bank1);

    // R3
    bank_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sb0 && !sb1) |=> !bank1);

    // R3
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sb0 == sb1) |=> $stable(bank1));

    // R8
    disp_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pp_q == DISP_P && non_sys && rd_addr >= DISP_N) |-> (rd_data == 8'h00));

    // R9
    empty_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pp_q >= GP_LIM && pp_q != DISP_P && non_sys) |-> (rd_data == 8'h00));

endmodule

bind banked_regfile banked_regfile_chk #(
    .GP_PAGES   (GP_PAGES),
    .DISP_PAGE  (DISP_PAGE),
    .DISP_BYTES (DISP_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pp_we    (pp_we),
    .pp_wdata (pp_wdata),
    .sb0      (sb0),
    .sb1      (sb1),
    .rd_addr  (rd_addr),
    .rd_mode  (rd_mode),
    .rd_data  (rd_data),
    .pp_q     (pp_q),
    .bank1    (bank1)
);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
    localparam int GP = 4;
    localparam int DISPP = 4;
    localparam int DB = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pp_we = 1'b0;
    logic [3:0] pp_wdata = '0;
    logic sb0 = 1'b0;
    logic sb1 = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [1:0] rd_mode = '0;
    logic [7:0] rd_data;
    logic wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [1:0] wr_mode = '0;
    logic [7:0] wr_data = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] model [int];
    int m_pp = 0;
    bit m_bank = 1'b0;

    always #10 clk = ~clk;

    banked_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .pp_we(pp_we), .pp_wdata(pp_wdata),
        .sb0(sb0), .sb1(sb1), .rd_addr(rd_addr), .rd_mode(rd_mode),
        .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_mode(wr_mode), .wr_data(wr_data)
    );

    // Key space of the reference: one band per storage kind, -1 = no storage
    function automatic int key_of(int a, int m, bit bk, int pg);
        if (a >= 192 && m == 0)
            return (a < 224) ? 30000 + a : 40000 + (bk ? 1000 : 0) + a;
        if (pg < GP)
            return (a < 192) ? 10000 + pg * 256 + a : 20000 + pg * 256 + a;
        if (pg == DISPP && a < DB)
            return 50000 + a;
        return -1;
    endfunction

    function automatic string tag_of(int rk, int wk, bit wen);
        if (wen && rk >= 0 && rk == wk) return "R10";
        if (rk < 0)      return (m_pp == DISPP) ? "R8" : "R9";
        if (rk < 20000)  return "R4";
        if (rk < 30000)  return "R7";
        if (rk < 40000)  return "R5";
        if (rk < 50000)  return "R6";
        return "R8";
    endfunction

    task automatic idle();
        pp_we = 1'b0; sb0 = 1'b0; sb1 = 1'b0; wr_en = 1'b0;
    endtask

    // One clock: compare read port, then advance the reference at the edge
    task automatic step(string tag);
        int rk;
        int wk;
        logic [7:0] exp;
        string t;
        #2;
        rk = key_of(int'(rd_addr), int'(rd_mode), m_bank, m_pp);
        wk = key_of(int'(wr_addr), int'(wr_mode), m_bank, m_pp);
        t = (tag != "") ? tag : tag_of(rk, wk, wr_en);
        if (rk < 0 || model.exists(rk)) begin
            exp = (rk < 0) ? 8'h00 : model[rk];
            checks++;
            if (rd_data !== exp) begin
                failures++;
                $display("FAIL %s: addr=%02h mode=%0d page=%0d bank=%0d actual=%02h expected=%02h",
                         t, rd_addr, rd_mode, m_pp, m_bank, rd_data, exp);
            end
        end
        @(posedge clk);
        if (wr_en && wk >= 0) model[wk] = wr_data;
        if (sb1 && !sb0) m_bank = 1'b1;
        if (sb0 && !sb1) m_bank = 1'b0;
        if (pp_we) m_pp = int'(pp_wdata);
        @(negedge clk);
    endtask

    task automatic set_page(int pg);
        idle(); pp_we = 1'b1; pp_wdata = 4'(pg); step("R2"); idle();
    endtask

    task automatic wr(logic [7:0] a, logic [1:0] m, logic [7:0] d);
        idle(); wr_en = 1'b1; wr_addr = a; wr_mode = m; wr_data = d;
        rd_addr = a; rd_mode = m; step(""); idle();
    endtask

    task automatic rd(logic [7:0] a, logic [1:0] m, string tag);
        idle(); rd_addr = a; rd_mode = m; step(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Fill all backed storage
        for (int pg = 0; pg < GP; pg++) begin
            set_page(pg);
            for (int a = 0; a < 256; a++) wr(8'(a), 2'd1, 8'($urandom));
        end
        set_page(DISPP);
        for (int a = 0; a < DB; a++) wr(8'(a), 2'd2, 8'($urandom));
        for (int a = 192; a < 256; a++) wr(8'(a), 2'd0, 8'($urandom));
        idle(); sb1 = 1'b1; step("R3"); idle();
        for (int a = 224; a < 256; a++) wr(8'(a), 2'd0, 8'($urandom));

        // R6: bank 1 differs, common shared
        wr(8'hE4, 2'd0, 8'h11);
        wr(8'hC4, 2'd0, 8'h22);
        idle(); sb0 = 1'b1; step("R3"); idle();
        wr(8'hE4, 2'd0, 8'h33);
        rd(8'hC4, 2'd0, "R6");
        idle(); sb1 = 1'b1; step("R3"); idle();
        rd(8'hE4, 2'd0, "R6");
        // R3: both selects together hold bank 1
        idle(); sb0 = 1'b1; sb1 = 1'b1; step("R3"); idle();
        rd(8'hE4, 2'd0, "R3");

        // R5: system set reachable from an empty page; R9 holes
        set_page(6);
        rd(8'hC4, 2'd0, "R5");
        rd(8'hE4, 2'd0, "R5");
        rd(8'hC4, 2'd1, "R9");
        wr(8'h20, 2'd3, 8'h77);
        rd(8'h20, 2'd3, "R9");

        // R8: display page holes
        set_page(DISPP);
        wr(8'h40, 2'd1, 8'h99);
        rd(8'h40, 2'd1, "R8");
        rd(8'h05, 2'd3, "R8");

        // R7 versus R5 aliasing, R10 same-cycle collision
        set_page(2);
        wr(8'hD0, 2'd1, 8'hA1);
        wr(8'hD0, 2'd0, 8'hB2);
        rd(8'hD0, 2'd2, "R7");
        rd(8'hD0, 2'd0, "R5");
        idle(); wr_en = 1'b1; wr_addr = 8'h30; wr_mode = 2'd3; wr_data = 8'h5A;
        rd_addr = 8'h30; rd_mode = 2'd0; step("R10"); idle();
        rd(8'h30, 2'd1, "R10");

        // R2: page change seen only from the next cycle
        idle(); pp_we = 1'b1; pp_wdata = 4'd1; rd_addr = 8'h30; rd_mode = 2'd1;
        step("R2"); idle();
        rd(8'h30, 2'd1, "R2");

        // R1: reset mid-run with bank 1 and page 3
        set_page(3);
        rst_n = 1'b0;
        @(negedge clk);
        m_bank = 1'b0; m_pp = 0;
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'hE4, 2'd0, "R1");
        rd(8'h30, 2'd1, "R1");

        // Mixed traffic
        for (int i = 0; i < 4000; i++) begin
            idle();
            rd_addr = ($urandom % 2 == 0) ? (8'hC0 | 8'($urandom % 64)) : 8'($urandom);
            rd_mode = 2'($urandom);
            wr_en   = ($urandom % 2 == 0);
            wr_data = 8'($urandom);
            if ($urandom % 5 == 0) begin
                wr_addr = rd_addr; wr_mode = rd_mode;
            end else begin
                wr_addr = ($urandom % 2 == 0) ? (8'hC0 | 8'($urandom % 64)) : 8'($urandom);
                wr_mode = 2'($urandom);
            end
            case ($urandom % 10)
                0: sb0 = 1'b1;
                1: sb1 = 1'b1;
                2: begin sb0 = 1'b1; sb1 = 1'b1; end
                default: ;
            endcase
            if ($urandom % 12 == 0) begin
                pp_we = 1'b1; pp_wdata = 4'($urandom % 8);
            end
            step("");
        end

        idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule